// File: doc/BRIEF.md
# Multi-Heartbeat Combining Chain

This block takes the liveness heartbeats of several independent processors and folds them into one heartbeat for a single downstream watchdog. Each source drives one stage of a short chain of flags. The first stage arms on its source's edge. Each later stage arms only if the stage before it is already armed when its own source produces an edge. When the last source produces an edge while the stage before it is armed, the merged output toggles and every flag clears.

Because every stage waits for its predecessor, the merged heartbeat keeps toggling only while every source keeps toggling. If any one source stops, the chain stalls at that stage and the watchdog fed by the merged output sees its heartbeat vanish. The merged period is never shorter than the slowest source's period and never longer than the sum of all source periods.

The heartbeats are asynchronous to the system clock. They are synchronized and edge-detected in the clock domain, and edges that arrive in the same cycle are resolved in stage order.

Top module: `hb_merge_chain`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `hb_out` to 0 and clears every stage flag.
- R2: A rising edge on the last source (`hb_in[2]`) while the middle stage is not armed leaves `hb_out` unchanged.
- R3: Rising edges on `hb_in[0]`, then `hb_in[1]`, then `hb_in[2]`, in separate cycles, toggle `hb_out` exactly once. The toggle appears on the third clock edge after the `hb_in[2]` rise is driven.
- R4: A rising edge on `hb_in[1]` while stage 0 is not armed is discarded. A later `hb_in[0]`, `hb_in[2]` sequence therefore does not toggle `hb_out`.
- R5: After a toggle, all flags are clear. A lone `hb_in[2]` edge, or an `hb_in[1]` edge followed by an `hb_in[2]` edge, then has no effect on `hb_out`.
- R6: Rising edges on all three sources in the same cycle, with no stage armed, toggle `hb_out` once, because they are processed in stage order.
- R7: While one source produces no edges, `hb_out` does not change, however many edges the other sources produce. The chain resumes from its held state once that source returns.
- R8: A reset asserted while stages are armed clears them. A subsequent `hb_in[2]` edge does not toggle `hb_out`.
- R9: Repeated `hb_in[0]` edges arm stage 0 only once. A same-cycle pair of `hb_in[1]` and `hb_in[2]` edges with stage 0 armed toggles `hb_out` once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hb_in | input | N_SRC | Asynchronous heartbeats, bit k feeds stage k |
| hb_out | output | 1 | Merged heartbeat, toggles once per completed chain |

## Verification
The chain is driven with the full in-order sequence, the three edges in one cycle, and a same-cycle pair on top of an armed first stage. Together these show that stage-order resolution completes the chain in every arrival pattern. Out-of-order edges, a lone final edge and repeated first-stage edges must all leave the output still, which separates a real handshake from a plain edge counter. A long run with one source silent shows that a single stalled source freezes the merged heartbeat, and that the chain resumes afterwards. A reset in the middle of a chain shows that armed flags are discarded and not carried into the next round.

// File: rtl/hb_merge_chain.sv
module hb_merge_chain #(
  parameter int N_SRC    = 3,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] hb_in,
  output logic             hb_out
);
  localparam int LAST = N_SRC - 1;

  logic [N_SRC-1:0] sync_q [SYNC_LEN];
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] edg;
  logic [LAST-1:0]  arm, arm_nxt;
  logic             fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_LEN; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= hb_in;
      for (int i = 1; i < SYNC_LEN; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_LEN-1];
    end
  end

  assign edg = sync_q[SYNC_LEN-1] & ~prev_q;

  always_comb begin
    arm_nxt[0] = arm[0] | edg[0];
    for (int k = 1; k < LAST; k++)
      arm_nxt[k] = arm[k] | (edg[k] & arm_nxt[k-1]);
  end

  assign fire = edg[LAST] & arm_nxt[LAST-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      arm    <= '0;
      hb_out <= 1'b0;
    end else if (fire) begin
      arm    <= '0;
      hb_out <= ~hb_out;
    end else begin
      arm    <= arm_nxt;
    end
  end
endmodule

// File: rtl/hb_merge_chain_chk.sv
module hb_merge_chain_chk #(
  parameter int N_SRC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] edg,
  input logic [N_SRC-2:0] arm,
  input logic             hb_out
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (hb_out == 1'b0 && arm == '0));

  p_chain_order_r4: assert property (@(posedge clk) disable iff (rst)
    arm[1] |-> arm[0]);

  p_toggle_needs_last_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(hb_out) |-> $past(edg[N_SRC-1]));

  p_flags_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(hb_out) |-> arm == '0);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (edg == '0) |=> ($stable(hb_out) && $stable(arm)));
endmodule

bind hb_merge_chain hb_merge_chain_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .edg(edg), .arm(arm), .hb_out(hb_out)
);

// File: tb/hb_merge_chain_tb.sv
module hb_merge_chain_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hb_in = '0;
  logic       hb_out;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_merge_chain #(.N_SRC(3), .SYNC_LEN(2)) dut_i (
    .clk(clk), .rst(rst), .hb_in(hb_in), .hb_out(hb_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] m);
    hb_in = m;
    tick(4);
    hb_in = '0;
    tick(4);
  endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (hb_out !== exp) begin
      errors++;
      $display("FAIL %s hb_out actual %b expected %b", req, hb_out, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R1");
  endtask

  task automatic t_lone_last();
    pulse(3'b100);
    check(1'b0, "R2");
  endtask

  task automatic t_in_order();
    hb_in = 3'b001; tick(4); hb_in = '0; tick(4);
    hb_in = 3'b010; tick(4); hb_in = '0; tick(4);
    hb_in = 3'b100;
    tick(2);
    check(1'b0, "R3");
    tick(1);
    check(1'b1, "R3");
    tick(1);
    hb_in = '0;
    tick(4);
    check(1'b1, "R3");
  endtask

  task automatic t_out_of_order();
    pulse(3'b010);
    pulse(3'b001);
    pulse(3'b100);
    check(1'b1, "R4");
    pulse(3'b010);
    pulse(3'b100);
    check(1'b0, "R4");
  endtask

  task automatic t_cleared();
    pulse(3'b100);
    check(1'b0, "R5");
    pulse(3'b010);
    pulse(3'b100);
    check(1'b0, "R5");
  endtask

  task automatic t_simultaneous();
    pulse(3'b111);
    check(1'b1, "R6");
  endtask

  task automatic t_stall();
    for (int i = 0; i < 6; i++) begin
      pulse(3'b001);
      pulse(3'b100);
    end
    check(1'b1, "R7");
    pulse(3'b010);
    pulse(3'b100);
    check(1'b0, "R7");
  endtask

  task automatic t_mid_reset();
    pulse(3'b111);
    check(1'b1, "R8");
    pulse(3'b001);
    pulse(3'b010);
    do_reset();
    check(1'b0, "R8");
    pulse(3'b100);
    check(1'b0, "R8");
  endtask

  task automatic t_double_arm();
    pulse(3'b001);
    pulse(3'b001);
    pulse(3'b100);
    check(1'b0, "R9");
    pulse(3'b110);
    check(1'b1, "R9");
    pulse(3'b100);
    check(1'b1, "R9");
  endtask

  initial begin
    tick(3);
    t_reset();
    t_lone_last();
    t_in_order();
    t_out_of_order();
    t_cleared();
    t_simultaneous();
    t_stall();
    t_mid_reset();
    t_double_arm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule